// File: doc/BRIEF.md
# Trace Record Attribute Cache

This block sits in a hardware trace compressor and removes repeated static attributes from a stream of trace records. Each record is either an instruction fetch or a data reference. An instruction fetch carries a physical address and a vector of attributes, such as the opcode word, the virtual address and the memory type. A data reference carries a data address and its own attribute vector. A direct-mapped table, indexed by the low bits of the instruction physical address, remembers the last instruction seen at each index. It also remembers the data references that followed that instruction, one slot for each position after it.

For every record the block makes a decision and passes the record through with it. The decision is a hit flag, which becomes the one header bit of the compressed record, plus two emit flags. One emit flag says whether an address or offset field must be written. The other says whether the full attribute vector must be written. A following stage does offset encoding and byte packing using these flags.

Records are handled strictly in order, one at a time. Each record spends one cycle in lookup and one cycle in update, so one new record can be accepted every two cycles.

Top module: `rec_attr_cache`

## Requirements
- R1: After reset, every table entry is invalid and no instruction context exists. `out_valid` is 0 and `in_ready` is 1, and the first instruction looked up after any reset misses.
- R2: The table index is the low log2(ENTRIES) bits of the instruction address. Two instructions with the same index but different addresses evict each other. An entry at a different index is not disturbed.
- R3: An instruction (`in_kind`=0) hits only when three conditions hold: its entry is valid, the full stored address equals `in_addr`, and the stored attributes equal `in_attr`. A matching address with any differing attribute bit is a miss. Every instruction miss rewrites the entry.
- R4: For an instruction, `out_emit_addr` is always 1 and `out_emit_attr` equals the inverse of `out_hit`.
- R5: A data reference (`in_kind`=1) is compared against, and on a miss written into, the entry of the most recent instruction. The slot is chosen by its position: the first data reference after an instruction uses slot 0, the next uses slot 1, and so on.
- R6: A data reference hits only when both of these hold: its instruction hit, and the slot holds a valid copy whose address and attributes equal the reference. On a data hit, `out_emit_addr` and `out_emit_attr` are both 0. On a data miss, both are 1.
- R7: Data references beyond the SLOTS-th after an instruction always miss and are not stored. A data reference arriving before any instruction since reset also misses and is not stored.
- R8: An instruction miss invalidates all data slots of its entry, so the data references that follow it miss.
- R9: A record accepted on a clock edge (`in_valid` and `in_ready` both high) drops `in_ready` for the next cycle. Its decision appears with `out_valid` high for exactly one cycle, starting two edges after acceptance. Decisions come out in acceptance order.
- R10: `out_kind`, `out_addr` and `out_attr` repeat the record that the decision belongs to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Record offered |
| in_ready | output | 1 | Block can accept a record this cycle |
| in_kind | input | 1 | 0 = instruction fetch, 1 = data reference |
| in_addr | input | ADDR_W | Physical address of the record |
| in_attr | input | ATTR_W | Attribute vector of the record |
| out_valid | output | 1 | Decision valid |
| out_kind | output | 1 | Kind of the decided record |
| out_addr | output | ADDR_W | Address of the decided record |
| out_attr | output | ATTR_W | Attributes of the decided record |
| out_hit | output | 1 | Header hit bit |
| out_emit_addr | output | 1 | Address/offset field must be emitted |
| out_emit_attr | output | 1 | Full attributes must be emitted |

## Verification
Directed sequences cover the cases that separate one kind of miss from another:
- the same address with a changed attribute vector, versus two addresses that alias to one index;
- data references sent in the same order versus in swapped order;
- a third reference that runs past the slots;
- a data reference arriving after a missed instruction, or before any instruction;
- a second reset in the middle of the run.

A long stream follows, with random interleaving over a small pool of addresses and attributes on a four-entry table. This produces frequent eviction and re-hits. A behavioural model in the bench predicts every decision and the ready/valid timing on each cycle.

// File: rtl/trc_pkg.sv
package trc_pkg;

  typedef enum logic {
    REC_INSTR = 1'b0,
    REC_DATA  = 1'b1
  } rec_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_UPD  = 2'd2
  } cache_state_e;

endpackage

// File: rtl/trc_table.sv
module trc_table #(
  parameter int ADDR_W  = 32,
  parameter int ATTR_W  = 48,
  parameter int ENTRIES = 64,
  parameter int SLOTS   = 2,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int TAG_W  = ADDR_W - IDX_W,
  localparam int SIDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [IDX_W-1:0]              rd_idx,
  output logic                          rd_valid,
  output logic [TAG_W-1:0]              rd_tag,
  output logic [ATTR_W-1:0]             rd_attr,
  output logic [SLOTS-1:0]              rd_svalid,
  output logic [SLOTS-1:0][ADDR_W-1:0]  rd_saddr,
  output logic [SLOTS-1:0][ATTR_W-1:0]  rd_sattr,
  input  logic                          wr_instr,
  input  logic                          wr_data,
  input  logic [IDX_W-1:0]              wr_idx,
  input  logic [SIDX_W-1:0]             wr_slot,
  input  logic [TAG_W-1:0]              wr_tag,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [ATTR_W-1:0]             wr_attr
);

  logic                          ent_v  [ENTRIES];
  logic [SLOTS-1:0]              ent_sv [ENTRIES];
  logic [TAG_W-1:0]              ent_tag[ENTRIES];
  logic [ATTR_W-1:0]             ent_at [ENTRIES];
  logic [SLOTS-1:0][ADDR_W-1:0]  ent_sa [ENTRIES];
  logic [SLOTS-1:0][ATTR_W-1:0]  ent_st [ENTRIES];

  // valid bits: reset, written by either kind of update
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < ENTRIES; e++) begin
        ent_v[e]  <= 1'b0;
        ent_sv[e] <= '0;
      end
    end else begin
      if (wr_instr) begin
        ent_v[wr_idx]  <= 1'b1;
        ent_sv[wr_idx] <= '0;
      end else if (wr_data) begin
        ent_sv[wr_idx][wr_slot] <= 1'b1;
      end
    end
  end

  // payload storage: no reset, guarded by the valid bits
  always_ff @(posedge clk) begin
    if (wr_instr) begin
      ent_tag[wr_idx] <= wr_tag;
      ent_at[wr_idx]  <= wr_attr;
    end
    if (wr_data) begin
      ent_sa[wr_idx][wr_slot] <= wr_addr;
      ent_st[wr_idx][wr_slot] <= wr_attr;
    end
  end

  always_comb begin
    rd_valid  = ent_v[rd_idx];
    rd_tag    = ent_tag[rd_idx];
    rd_attr   = ent_at[rd_idx];
    rd_svalid = ent_sv[rd_idx];
    rd_saddr  = ent_sa[rd_idx];
    rd_sattr  = ent_st[rd_idx];
  end

endmodule

// File: rtl/trc_match.sv
module trc_match import trc_pkg::*; #(
  parameter int ADDR_W  = 32,
  parameter int ATTR_W  = 48,
  parameter int ENTRIES = 64,
  parameter int SLOTS   = 2,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int TAG_W  = ADDR_W - IDX_W,
  localparam int CNT_W  = $clog2(SLOTS + 1),
  localparam int SIDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  rec_kind_e                     kind,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [ATTR_W-1:0]             attr,
  input  logic                          ctx_valid,
  input  logic                          ctx_ihit,
  input  logic [CNT_W-1:0]              ctx_cnt,
  input  logic                          rd_valid,
  input  logic [TAG_W-1:0]              rd_tag,
  input  logic [ATTR_W-1:0]             rd_attr,
  input  logic [SLOTS-1:0]              rd_svalid,
  input  logic [SLOTS-1:0][ADDR_W-1:0]  rd_saddr,
  input  logic [SLOTS-1:0][ATTR_W-1:0]  rd_sattr,
  output logic                          hit,
  output logic                          upd_instr,
  output logic                          upd_data,
  output logic [SIDX_W-1:0]             slot
);

  localparam logic [CNT_W-1:0] SLOTS_C = CNT_W'(SLOTS);

  logic [SLOTS-1:0] slot_eq;
  logic             instr_eq;
  logic             in_range;

  // one comparator per data slot
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot_cmp
    assign slot_eq[s] = rd_svalid[s] && (rd_saddr[s] == addr) && (rd_sattr[s] == attr);
  end

  always_comb begin
    instr_eq  = rd_valid && (rd_tag == addr[ADDR_W-1:IDX_W]) && (rd_attr == attr);
    in_range  = ctx_valid && (ctx_cnt < SLOTS_C);
    slot      = ctx_cnt[SIDX_W-1:0];
    hit       = 1'b0;
    upd_instr = 1'b0;
    upd_data  = 1'b0;
    if (kind == REC_INSTR) begin
      hit       = instr_eq;
      upd_instr = !instr_eq;
    end else begin
      hit      = in_range && ctx_ihit && slot_eq[slot];
      upd_data = in_range && !hit;
    end
  end

endmodule

// File: rtl/rec_attr_cache.sv
module rec_attr_cache import trc_pkg::*; #(
  parameter int ADDR_W  = 32,
  parameter int ATTR_W  = 48,
  parameter int ENTRIES = 64,
  parameter int SLOTS   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_kind,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [ATTR_W-1:0] in_attr,
  output logic              out_valid,
  output logic              out_kind,
  output logic [ADDR_W-1:0] out_addr,
  output logic [ATTR_W-1:0] out_attr,
  output logic              out_hit,
  output logic              out_emit_addr,
  output logic              out_emit_attr
);

  localparam int IDX_W  = $clog2(ENTRIES);
  localparam int TAG_W  = ADDR_W - IDX_W;
  localparam int CNT_W  = $clog2(SLOTS + 1);
  localparam int SIDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam logic [CNT_W-1:0] SLOTS_C = CNT_W'(SLOTS);

  cache_state_e state_q, state_d;
  logic accept, look_en;

  // captured record
  rec_kind_e         stg_kind_q;
  logic [ADDR_W-1:0] stg_addr_q;
  logic [ATTR_W-1:0] stg_attr_q;

  // instruction context for following data references
  logic             ctx_valid_q, ctx_valid_d;
  logic             ctx_ihit_q,  ctx_ihit_d;
  logic [IDX_W-1:0] ctx_idx_q,   ctx_idx_d;
  logic [CNT_W-1:0] ctx_cnt_q,   ctx_cnt_d;

  // lookup result held for the update cycle
  logic              res_hit_q;
  logic              res_wi_q, res_wi_d;
  logic              res_wd_q, res_wd_d;
  logic [IDX_W-1:0]  res_idx_q;
  logic [SIDX_W-1:0] res_slot_q;

  // table and match wiring
  logic [IDX_W-1:0]             rd_idx;
  logic                         rd_valid;
  logic [TAG_W-1:0]             rd_tag;
  logic [ATTR_W-1:0]            rd_attr;
  logic [SLOTS-1:0]             rd_svalid;
  logic [SLOTS-1:0][ADDR_W-1:0] rd_saddr;
  logic [SLOTS-1:0][ATTR_W-1:0] rd_sattr;
  logic                         m_hit, m_upd_i, m_upd_d;
  logic [SIDX_W-1:0]            m_slot;
  logic                         wr_instr, wr_data;

  assign in_ready = (state_q != ST_LOOK);
  assign accept   = in_valid && in_ready;
  assign look_en  = (state_q == ST_LOOK);

  // next state
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (accept) state_d = ST_LOOK;
      ST_LOOK: state_d = ST_UPD;
      ST_UPD:  state_d = accept ? ST_LOOK : ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // record capture, enabled by accept
  always_ff @(posedge clk) begin
    if (accept) begin
      stg_kind_q <= rec_kind_e'(in_kind);
      stg_addr_q <= in_addr;
      stg_attr_q <= in_attr;
    end
  end

  // lookup index: instructions use their address, data uses the context
  always_comb begin
    if (stg_kind_q == REC_INSTR) rd_idx = stg_addr_q[IDX_W-1:0];
    else                         rd_idx = ctx_idx_q;
  end

  trc_table #(
    .ADDR_W(ADDR_W), .ATTR_W(ATTR_W), .ENTRIES(ENTRIES), .SLOTS(SLOTS)
  ) u_table (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_attr(rd_attr),
    .rd_svalid(rd_svalid), .rd_saddr(rd_saddr), .rd_sattr(rd_sattr),
    .wr_instr(wr_instr), .wr_data(wr_data), .wr_idx(res_idx_q), .wr_slot(res_slot_q),
    .wr_tag(stg_addr_q[ADDR_W-1:IDX_W]), .wr_addr(stg_addr_q), .wr_attr(stg_attr_q)
  );

  trc_match #(
    .ADDR_W(ADDR_W), .ATTR_W(ATTR_W), .ENTRIES(ENTRIES), .SLOTS(SLOTS)
  ) u_match (
    .kind(stg_kind_q), .addr(stg_addr_q), .attr(stg_attr_q),
    .ctx_valid(ctx_valid_q), .ctx_ihit(ctx_ihit_q), .ctx_cnt(ctx_cnt_q),
    .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_attr(rd_attr),
    .rd_svalid(rd_svalid), .rd_saddr(rd_saddr), .rd_sattr(rd_sattr),
    .hit(m_hit), .upd_instr(m_upd_i), .upd_data(m_upd_d), .slot(m_slot)
  );

  // context next state, advanced during lookup
  always_comb begin
    ctx_valid_d = ctx_valid_q;
    ctx_ihit_d  = ctx_ihit_q;
    ctx_idx_d   = ctx_idx_q;
    ctx_cnt_d   = ctx_cnt_q;
    if (look_en) begin
      if (stg_kind_q == REC_INSTR) begin
        ctx_valid_d = 1'b1;
        ctx_ihit_d  = m_hit;
        ctx_idx_d   = rd_idx;
        ctx_cnt_d   = '0;
      end else if (ctx_cnt_q < SLOTS_C) begin
        ctx_cnt_d = ctx_cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctx_valid_q <= 1'b0;
      ctx_ihit_q  <= 1'b0;
      ctx_idx_q   <= '0;
      ctx_cnt_q   <= '0;
    end else begin
      ctx_valid_q <= ctx_valid_d;
      ctx_ihit_q  <= ctx_ihit_d;
      ctx_idx_q   <= ctx_idx_d;
      ctx_cnt_q   <= ctx_cnt_d;
    end
  end

  // write strobes: only meaningful from a real lookup
  always_comb begin
    res_wi_d = look_en && m_upd_i;
    res_wd_d = look_en && m_upd_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_wi_q <= 1'b0;
      res_wd_q <= 1'b0;
    end else begin
      res_wi_q <= res_wi_d;
      res_wd_q <= res_wd_d;
    end
  end

  always_ff @(posedge clk) begin
    if (look_en) begin
      res_hit_q  <= m_hit;
      res_idx_q  <= rd_idx;
      res_slot_q <= m_slot;
    end
  end

  assign wr_instr = (state_q == ST_UPD) && res_wi_q;
  assign wr_data  = (state_q == ST_UPD) && res_wd_q;

  // decision stream
  always_comb begin
    out_valid     = (state_q == ST_UPD);
    out_kind      = stg_kind_q;
    out_addr      = stg_addr_q;
    out_attr      = stg_attr_q;
    out_hit       = res_hit_q;
    out_emit_addr = (stg_kind_q == REC_INSTR) || !res_hit_q;
    out_emit_attr = !res_hit_q;
  end

endmodule

// File: rtl/rec_attr_cache_chk.sv
module rec_attr_cache_chk #(
  parameter int SLOTS = 2
) (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic in_kind,
  input logic out_valid,
  input logic out_kind,
  input logic out_hit,
  input logic out_emit_addr,
  input logic out_emit_attr
);

  logic       seen_instr;
  logic       last_ihit;
  logic [7:0] dcnt;
  logic       acc_kind;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_instr <= 1'b0;
      last_ihit  <= 1'b0;
      dcnt       <= '0;
      acc_kind   <= 1'b0;
    end else begin
      if (in_valid && in_ready) acc_kind <= in_kind;
      if (out_valid) begin
        if (!out_kind) begin
          seen_instr <= 1'b1;
          last_ihit  <= out_hit;
          dcnt       <= '0;
        end else if (dcnt != 8'hFF) begin
          dcnt <= dcnt + 8'd1;
        end
      end
    end
  end

  p_ready_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  p_out_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> ##1 out_valid);

  p_out_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  p_kind_echo_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_kind == acc_kind));

  p_instr_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_kind) |-> out_emit_addr);

  p_miss_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_hit) |-> (out_emit_addr && out_emit_attr));

  p_data_ihit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_kind && out_hit) |-> (seen_instr && last_ihit));

  p_data_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_kind && (int'(dcnt) >= SLOTS)) |-> !out_hit);

endmodule

bind rec_attr_cache rec_attr_cache_chk #(.SLOTS(SLOTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_kind(in_kind), .out_valid(out_valid), .out_kind(out_kind),
  .out_hit(out_hit), .out_emit_addr(out_emit_addr), .out_emit_attr(out_emit_attr)
);

// File: tb/rec_attr_cache_test.sv
module rec_attr_cache_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int TW = 48;
  localparam int NE = 4;
  localparam int NS = 2;

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic          in_ready;
  logic          in_kind;
  logic [AW-1:0] in_addr;
  logic [TW-1:0] in_attr;
  logic          out_valid;
  logic          out_kind;
  logic [AW-1:0] out_addr;
  logic [TW-1:0] out_attr;
  logic          out_hit;
  logic          out_emit_addr;
  logic          out_emit_attr;

  rec_attr_cache #(.ADDR_W(AW), .ATTR_W(TW), .ENTRIES(NE), .SLOTS(NS)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_kind(in_kind), .in_addr(in_addr), .in_attr(in_attr),
    .out_valid(out_valid), .out_kind(out_kind), .out_addr(out_addr), .out_attr(out_attr),
    .out_hit(out_hit), .out_emit_addr(out_emit_addr), .out_emit_attr(out_emit_attr)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  typedef struct {
    bit          kind;
    logic [AW-1:0] addr;
    logic [TW-1:0] attr;
    bit          hit;
    bit          eaddr;
    bit          eattr;
    string       req;
  } exp_t;

  exp_t exq[$];

  // behavioural reference model
  bit            m_v  [NE];
  logic [AW-1:0] m_a  [NE];
  logic [TW-1:0] m_t  [NE];
  bit            m_sv [NE][NS];
  logic [AW-1:0] m_sa [NE][NS];
  logic [TW-1:0] m_st [NE][NS];
  bit            c_valid;
  bit            c_ihit;
  int            c_idx;
  int            c_cnt;

  task automatic model_reset();
    for (int e = 0; e < NE; e++) begin
      m_v[e] = 0;
      for (int s = 0; s < NS; s++) m_sv[e][s] = 0;
    end
    c_valid = 0; c_ihit = 0; c_idx = 0; c_cnt = 0;
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic send(input bit k, input logic [AW-1:0] a, input logic [TW-1:0] t,
                      input string req);
    exp_t e;
    int   idx;
    e.kind = k; e.addr = a; e.attr = t; e.req = req;
    if (!k) begin
      idx   = int'(a % NE);
      e.hit = m_v[idx] && (m_a[idx] == a) && (m_t[idx] == t);
      if (!e.hit) begin
        m_v[idx] = 1; m_a[idx] = a; m_t[idx] = t;
        for (int s = 0; s < NS; s++) m_sv[idx][s] = 0;
      end
      c_valid = 1; c_ihit = e.hit; c_idx = idx; c_cnt = 0;
      e.eaddr = 1;
    end else begin
      if (c_valid && c_cnt < NS) begin
        e.hit = c_ihit && m_sv[c_idx][c_cnt] && (m_sa[c_idx][c_cnt] == a)
                && (m_st[c_idx][c_cnt] == t);
        if (!e.hit) begin
          m_sv[c_idx][c_cnt] = 1; m_sa[c_idx][c_cnt] = a; m_st[c_idx][c_cnt] = t;
        end
        c_cnt++;
      end else begin
        e.hit = 0;
      end
      e.eaddr = !e.hit;
    end
    e.eattr = !e.hit;
    exq.push_back(e);
    @(negedge clk);
    in_valid = 1'b1; in_kind = k; in_addr = a; in_attr = t;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    repeat (4) @(negedge clk);
    check(exq.size() == 0, "R9", "pending decisions", exq.size(), 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // cycle-by-cycle comparison
  bit acc_d1, acc_d2;
  always @(negedge clk) begin
    bit   acc_now;
    exp_t e;
    #1;
    if (!rst_n) begin
      acc_d1 = 0; acc_d2 = 0;
      check(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
    end else if (!done) begin
      acc_now = in_valid && in_ready;
      check(in_ready == !acc_d1, "R9", "in_ready", in_ready, !acc_d1);
      check(out_valid == acc_d2, "R9", "out_valid timing", out_valid, acc_d2);
      if (out_valid) begin
        if (exq.size() == 0) begin
          check(0, "R9", "unexpected decision", 1, 0);
        end else begin
          e = exq.pop_front();
          check(out_hit == e.hit, e.req, "out_hit", out_hit, e.hit);
          check(out_emit_addr == e.eaddr, e.kind ? "R6" : "R4", "out_emit_addr",
                out_emit_addr, e.eaddr);
          check(out_emit_attr == e.eattr, e.kind ? "R6" : "R4", "out_emit_attr",
                out_emit_attr, e.eattr);
          check(out_kind == e.kind, "R10", "out_kind", out_kind, e.kind);
          check(out_addr == e.addr, "R10", "out_addr", out_addr, e.addr);
          check(out_attr == e.attr, "R10", "out_attr", out_attr, e.attr);
        end
      end
      acc_d2 = acc_d1;
      acc_d1 = acc_now;
    end
  end

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_cmp++; n_bad++;
    $display("FAIL R9 watchdog: actual=hung expected=finished");
    finish_run();
  end

  localparam logic [AW-1:0] A0 = 32'h0000_1000;  // index 0
  localparam logic [AW-1:0] A1 = 32'h0000_1004;  // index 0, aliases A0 (R2)
  localparam logic [AW-1:0] A2 = 32'h0000_1001;  // index 1
  localparam logic [TW-1:0] TX = 48'h1111_2222_3333;
  localparam logic [TW-1:0] TY = 48'h1111_2222_3337;

  initial begin
    in_valid = 0; in_kind = 0; in_addr = '0; in_attr = '0;
    rst_n = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    #1;
    check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
    check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    rst_n = 1'b1;

    send(1, 32'h100, 48'h5, "R7");        // data before any instruction
    send(0, A0, TX, "R1");                // first lookup misses
    send(1, 32'h2000, 48'hA, "R5");       // slot 0
    send(1, 32'h2040, 48'hB, "R5");       // slot 1
    send(1, 32'h2080, 48'hC, "R7");       // beyond slots
    send(0, A0, TX, "R3");                // full match hit
    send(1, 32'h2000, 48'hA, "R6");       // data hit
    send(1, 32'h2040, 48'hB, "R6");
    send(1, 32'h2080, 48'hC, "R7");       // still not stored
    send(0, A0, TX, "R3");
    send(1, 32'h2040, 48'hB, "R5");       // wrong order: slot 0 miss
    send(0, A0, TX, "R3");
    send(1, 32'h2040, 48'hB, "R5");       // now slot 0 holds it
    send(1, 32'h2040, 48'hC, "R6");       // attribute-only difference
    send(0, A0, TY, "R3");                // same address, new attrs
    send(1, 32'h2040, 48'hB, "R8");       // slots cleared
    send(0, A0, TY, "R3");
    send(1, 32'h2040, 48'hB, "R6");
    send(0, A2, TX, "R2");                // other index
    send(0, A1, TY, "R2");                // evicts A0
    send(0, A0, TY, "R2");                // misses after eviction
    send(0, A2, TX, "R2");                // untouched index hits
    drain();

    do_reset();
    send(0, A2, TX, "R1");                // table cleared by reset
    send(0, A2, TX, "R3");
    drain();

    for (int i = 0; i < 3000; i++) begin
      bit            k;
      logic [AW-1:0] a;
      logic [TW-1:0] t;
      k = ($urandom % 3) == 0 ? 1'b0 : (($urandom % 2) == 0);
      if (!k) a = 32'h4000 + ($urandom % 6);
      else    a = 32'h8000 + 4 * ($urandom % 3);
      t = 48'(($urandom % 8) < 7 ? 48'h77 : 48'h78);
      send(k, a, t, k ? "R6" : "R3");
    end
    drain();
    finish_run();
  end

endmodule